// File: doc/BRIEF.md
# Serial PLL programming master

This block runs a three-wire serial programming link to a clock-synthesizer device. It has a serial clock, an active-low chip select and a bidirectional data line, and it uses them to write or read 11-bit registers at 3-bit addresses. The host side pulses `start` with a read/write flag, an address and write data. When the last frame is finished, the block pulses `done` and presents any captured register value on `rdata`.

Each serial clock period takes two step ticks, one low half and one high half. Each tick comes from a divider of the system clock and stands in for one access by software. A frame has sixteen rising edges. The first fifteen come with chip select low, and the sixteenth comes with chip select high and commits the frame. A write uses one frame. A read uses two frames. The first is an address-load frame with the read flag set. In the second, the data line is released and the device shifts its register out. This read-out frame starts one bit earlier than a write frame, so valid bits arrive on the first rising edge.

The data line is modelled as an output, an output enable and an input. The output and enable drive the pad. The input is the value seen at the pad.

Top module: `pll_serial_master`

## Requirements
- R1: While idle, and during reset, `sclk` is 0, `cs_n` is 1, `sdata_oe` is 0 and `done` is 0. A reset in the middle of a frame returns all four at once.
- R2: A write transaction gives exactly 16 rising edges of `sclk`. `cs_n` is 0 at edges 1 to 15 and 1 at edge 16.
- R3: In a write frame, `sdata_o` at rising edge 1 is the direction bit, with 0 meaning write. At edges 2 to 4 it carries the address, bit 0 first. At edges 5 to 15 it carries the write data, bit 0 first.
- R4: A read transaction gives 32 rising edges in two frames. The first frame has direction bit 1 at edge 1 and the address, bit 0 first, at edges 2 to 4. It drives 0 at edges 5 to 15.
- R5: `sdata_oe` is 1 at every rising edge of a write frame or address-load frame. It is 0 at every rising edge of the read-out frame. In the read-out frame, `cs_n` is 0 at edges 1 to 15 and 1 at edge 16.
- R6: In the read-out frame, `sdata_i` is sampled at each rising edge. The samples from edges 4 to 14 form `rdata`, with edge 4 giving bit 0. The samples from edges 1 to 3 and edge 15 are discarded. A write leaves `rdata` unchanged.
- R7: `done` is high for exactly one system clock per transaction. It comes after the last rising edge of the final frame.
- R8: A `start` pulse while a transaction is running is ignored. The running frames, their edge count and the single `done` are unchanged.
- R9: `sclk` stays high for exactly `TICK_DIV` system clocks per rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Data to write |
| rdata | output | DATA_W | Last value read from the device |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| sdata_o | output | 1 | Serial data driven toward the device |
| sdata_oe | output | 1 | Drive enable for the data pad |
| sdata_i | input | 1 | Serial data seen at the pad |

## Verification
The in-line assertions check the cycle-level invariants at every clock. These are the quiet idle outputs, the edge counter staying inside the frame, an address-load frame always coming before a read-out frame, the one-cycle `done`, sequencer state held against a `start` while busy, and the capture register changing only on rising edges. Bit order and frame alignment can only be shown by the bench's scenarios. These cover the direction and address bits in both frame kinds, the discarded first three and fifteenth read-out samples, data retention across writes, the high-half duration, and recovery from a reset in mid-frame. A device model in the bench drives those scenarios.

// File: rtl/pllsp_pkg.sv
package pllsp_pkg;
   // Kind of frame currently being clocked out.
   typedef enum logic [1:0] {
      FR_WRITE   = 2'd0,
      FR_SETUP   = 2'd1,
      FR_READOUT = 2'd2
   } frame_e;
endpackage

// File: rtl/pllsp_tick_gen.sv
module pllsp_tick_gen #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] TOP = CW'(TICK_DIV - 1);

   logic [CW-1:0] cnt;

   // Counter restarts whenever the sequencer is idle, so every frame
   // starts with a full low half.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt == TOP) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == TOP);
endmodule

// File: rtl/pllsp_sequencer.sv
module pllsp_sequencer
   import pllsp_pkg::*;
#(
   parameter int FRAME_EDGES = 16,
   parameter int EW          = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start,
   input  logic          rw_in,
   output logic          busy,
   output logic          phase_hi,
   output logic [EW-1:0] edge_cnt,
   output frame_e        frame,
   output logic          rise,
   output logic          fin,
   output logic          done
);
   localparam logic [EW-1:0] LAST_E  = EW'(FRAME_EDGES);
   localparam logic [EW-1:0] FIRST_E = EW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         phase_hi <= 1'b0;
         edge_cnt <= FIRST_E;
         frame    <= FR_WRITE;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy     <= 1'b1;
               phase_hi <= 1'b0;
               edge_cnt <= FIRST_E;
               frame    <= rw_in ? FR_SETUP : FR_WRITE;
            end
         end else if (tick) begin
            if (!phase_hi) begin
               phase_hi <= 1'b1;
            end else begin
               phase_hi <= 1'b0;
               if (edge_cnt == LAST_E) begin
                  if (frame == FR_SETUP) begin
                     frame    <= FR_READOUT;
                     edge_cnt <= FIRST_E;
                  end else begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end
               end else begin
                  edge_cnt <= edge_cnt + 1'b1;
               end
            end
         end
      end
   end

   assign rise = busy && tick && !phase_hi;
   assign fin  = busy && tick && phase_hi && (edge_cnt == LAST_E) &&
                 (frame == FR_READOUT);

   // R2: the edge counter never leaves the frame while a transaction runs
   a_r2_edge_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (edge_cnt >= FIRST_E) && (edge_cnt <= LAST_E));

   // R4: a read-out frame is only ever entered from an address-load frame
   a_r4_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
      (frame == FR_READOUT) && ($past(frame) != FR_READOUT)
      |-> $past(frame) == FR_SETUP);

   // R7: done lasts one system clock
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: a start while busy leaves the running sequence untouched
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && !tick |=> busy && $stable(edge_cnt) &&
      $stable(phase_hi) && $stable(frame));
endmodule

// File: rtl/pllsp_shifter.sv
module pllsp_shifter
   import pllsp_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 11,
   parameter int EW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              rw_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic [EW-1:0]     edge_cnt,
   input  frame_e            frame,
   input  logic              rise,
   input  logic              fin,
   input  logic              sdata_i,
   output logic              sdata_o,
   output logic [DATA_W-1:0] rdata
);
   localparam int TXW = 1 + ADDR_W + DATA_W;
   localparam logic [EW-1:0] CAP_LO = EW'(ADDR_W + 1);
   localparam logic [EW-1:0] CAP_HI = EW'(ADDR_W + DATA_W);

   logic              rw_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] wdata_eff;
   logic [TXW-1:0]    tx_word;
   logic              cap_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rw_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (load) begin
         rw_q    <= rw_in;
         addr_q  <= addr_in;
         wdata_q <= wdata_in;
      end
   end

   // Outgoing word, sent from bit 0: direction, address, then data.
   assign wdata_eff = rw_q ? '0 : wdata_q;
   assign tx_word   = {wdata_eff, addr_q, rw_q};

   always_comb begin
      sdata_o = 1'b0;
      if (frame != FR_READOUT) begin
         for (int i = 0; i < TXW; i++) begin
            if (edge_cnt == EW'(i + 1)) sdata_o = tx_word[i];
         end
      end
   end

   // The read-out frame is one bit early: address bits come on edges
   // 1..ADDR_W, data on the following DATA_W edges, the rest is dropped.
   assign cap_en = rise && (frame == FR_READOUT) &&
                   (edge_cnt >= CAP_LO) && (edge_cnt <= CAP_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shreg <= '0;
      else if (cap_en) shreg <= {sdata_i, shreg[DATA_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rdata <= '0;
      else if (fin) rdata <= shreg;
   end

   // R6: the capture register only moves on a serial rising edge
   a_r6_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(shreg));

   // R6: read data changes only when a read-out frame completes
   a_r6_rdata_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> $stable(rdata));
endmodule

// File: rtl/pll_serial_master.sv
module pll_serial_master
   import pllsp_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 11,
   parameter int TICK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic              sclk,
   output logic              cs_n,
   output logic              sdata_o,
   output logic              sdata_oe,
   input  logic              sdata_i
);
   localparam int FRAME_EDGES = 1 + ADDR_W + DATA_W + 1;
   localparam int EW          = $clog2(FRAME_EDGES + 1);
   localparam logic [EW-1:0] LAST_E = EW'(FRAME_EDGES);

   generate
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("pll_serial_master: ADDR_W must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("pll_serial_master: DATA_W must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_tick_div
         $error("pll_serial_master: TICK_DIV must be at least 1");
      end
   endgenerate

   logic          busy;
   logic          phase_hi;
   logic          tick;
   logic          rise;
   logic          fin;
   logic [EW-1:0] edge_cnt;
   frame_e        frame;

   pllsp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   pllsp_sequencer #(.FRAME_EDGES(FRAME_EDGES), .EW(EW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .start    (start),
      .rw_in    (rd_wr),
      .busy     (busy),
      .phase_hi (phase_hi),
      .edge_cnt (edge_cnt),
      .frame    (frame),
      .rise     (rise),
      .fin      (fin),
      .done     (done)
   );

   pllsp_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EW(EW)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start && !busy),
      .rw_in    (rd_wr),
      .addr_in  (addr),
      .wdata_in (wdata),
      .edge_cnt (edge_cnt),
      .frame    (frame),
      .rise     (rise),
      .fin      (fin),
      .sdata_i  (sdata_i),
      .sdata_o  (sdata_o),
      .rdata    (rdata)
   );

   assign sclk     = busy && phase_hi;
   assign cs_n     = !busy || (edge_cnt == LAST_E);
   assign sdata_oe = busy && (frame != FR_READOUT);

   // R1: the link is quiet whenever no transaction runs
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk && cs_n && !sdata_oe);

   // R5: the pad is never driven while the serial clock is high in read-out
   a_r5_released_readout: assert property (@(posedge clk) disable iff (!rst_n)
      sclk && (frame == FR_READOUT) |-> !sdata_oe);
endmodule

// File: tb/pll_serial_master_tb.sv
`timescale 1ns/1ps
module pll_serial_master_tb_top;
   localparam int AW = 3;
   localparam int DW = 11;
   localparam int TD = 4;

   typedef struct packed {
      logic          rw;
      logic [AW-1:0] addr;
      logic [DW-1:0] wd;
      logic [DW-1:0] dv;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 3'd5, 11'h5A3, 11'h000},
      '{1'b1, 3'd2, 11'h000, 11'h6B1},
      '{1'b0, 3'd0, 11'h7FF, 11'h000},
      '{1'b1, 3'd7, 11'h000, 11'h001},
      '{1'b1, 3'd1, 11'h000, 11'h400},
      '{1'b0, 3'd6, 11'h001, 11'h000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic rd_wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic done, sclk, cs_n, sdata_o, sdata_oe, sdata_i;

   always #2.5 clk = ~clk;

   pll_serial_master #(.ADDR_W(AW), .DATA_W(DW), .TICK_DIV(TD)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_wr(rd_wr),
      .addr(addr), .wdata(wdata), .rdata(rdata), .done(done),
      .sclk(sclk), .cs_n(cs_n), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
      .sdata_i(sdata_i)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // Device model: records each rising edge, answers the read-out frame.
   logic          rec = 1'b0;
   int            ecnt = 0;
   logic [31:0]   got_do, got_cs, got_oe;
   logic [DW-1:0] dev_val = '0;
   logic [AW-1:0] dev_addr = '0;
   logic [14:0]   dev_seq;
   int            hi_clks = 0;
   int            done_cnt = 0;

   // read-out order: address bits, data bits, then a junk 1 on edge 15
   assign dev_seq = {1'b1, dev_val, dev_addr};
   assign sdata_i = (ecnt >= 16 && ecnt <= 30) ? dev_seq[ecnt - 16] : 1'b0;

   always @(posedge sclk) begin
      if (rec) begin
         if (ecnt < 32) begin
            got_do[ecnt] = sdata_o;
            got_cs[ecnt] = cs_n;
            got_oe[ecnt] = sdata_oe;
         end
         ecnt = ecnt + 1;
      end
   end

   always @(posedge clk) begin
      if (rec && done) done_cnt = done_cnt + 1;
      if (rec && sclk) hi_clks = hi_clks + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      chk(sclk == 1'b0, req, "sclk idle", 32'(sclk), 32'h0);
      chk(cs_n == 1'b1, req, "cs_n idle", 32'(cs_n), 32'h1);
      chk(sdata_oe == 1'b0, req, "oe idle", 32'(sdata_oe), 32'h0);
      chk(done == 1'b0, req, "done idle", 32'(done), 32'h0);
   endtask

   logic [DW-1:0] last_rd = '0;

   task automatic run_txn(input vec_t v, input bit poke_busy);
      int n;
      int edges_at_done;
      int exp_edges;
      logic [15:0] exp_tx;
      dev_val  = v.dv;
      dev_addr = v.addr;
      ecnt = 0; got_do = '0; got_cs = '0; got_oe = '0;
      hi_clks = 0; done_cnt = 0; rec = 1'b1;
      @(negedge clk);
      start = 1'b1; rd_wr = v.rw; addr = v.addr; wdata = v.wd;
      @(negedge clk);
      start = 1'b0;
      if (poke_busy) begin
         repeat (20) @(negedge clk);
         start = 1'b1; rd_wr = ~v.rw; addr = ~v.addr; wdata = ~v.wd;
         @(negedge clk);
         start = 1'b0;
      end
      n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      edges_at_done = ecnt;
      chk(n < 5000, "R7", "done seen", 32'(n), 32'd5000);
      repeat (3) @(negedge clk);
      rec = 1'b0;

      exp_edges = v.rw ? 32 : 16;
      exp_tx = {1'b0, (v.rw ? 11'h000 : v.wd), v.addr, v.rw};
      if (v.rw) begin
         chk(ecnt == 32, "R4", "edge count", 32'(ecnt), 32'd32);
         chk(got_do[14:0] == exp_tx[14:0], "R4", "setup bits",
             32'(got_do[14:0]), 32'(exp_tx[14:0]));
         chk(got_cs == 32'h8000_8000, "R5", "cs pattern", got_cs, 32'h8000_8000);
         chk(got_oe == 32'h0000_FFFF, "R5", "oe pattern", got_oe, 32'h0000_FFFF);
         last_rd = v.dv;
      end else begin
         chk(ecnt == 16, "R2", "edge count", 32'(ecnt), 32'd16);
         chk(got_cs[15:0] == 16'h8000, "R2", "cs pattern",
             32'(got_cs[15:0]), 32'h8000);
         chk(got_do[14:0] == exp_tx[14:0], "R3", "write bits",
             32'(got_do[14:0]), 32'(exp_tx[14:0]));
         chk(got_oe[15:0] == 16'hFFFF, "R5", "oe pattern",
             32'(got_oe[15:0]), 32'hFFFF);
      end
      chk(rdata == last_rd, "R6", "rdata", 32'(rdata), 32'(last_rd));
      chk(done_cnt == 1, "R7", "done pulses", 32'(done_cnt), 32'd1);
      chk(edges_at_done == exp_edges, "R7", "edges before done",
          32'(edges_at_done), 32'(exp_edges));
      chk(hi_clks == exp_edges * TD, "R9", "sclk high clocks",
          32'(hi_clks), 32'(exp_edges * TD));
      check_idle("R1");
      if (poke_busy)
         chk(ecnt == exp_edges && done_cnt == 1, "R8", "busy start ignored",
             32'(ecnt), 32'(exp_edges));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check_idle("R1");
      chk(rdata == '0, "R6", "rdata after reset", 32'(rdata), 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("R1");

      for (int i = 0; i < NV; i++) run_txn(VECS[i], 1'b0);

      // R8: start pulsed during a write and during a read
      run_txn('{1'b0, 3'd3, 11'h2C5, 11'h000}, 1'b1);
      run_txn('{1'b1, 3'd4, 11'h000, 11'h355}, 1'b1);

      // R1: reset in the middle of a frame
      @(negedge clk);
      start = 1'b1; rd_wr = 1'b0; addr = 3'd5; wdata = 11'h123;
      @(negedge clk);
      start = 1'b0;
      repeat (41) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R1");
      chk(rdata == '0, "R1", "rdata cleared", 32'(rdata), 32'h0);
      last_rd = '0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_txn('{1'b0, 3'd2, 11'h4A9, 11'h000}, 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule